// File: doc/BRIEF.md
# Multi-Channel Timer Output Controller

This block turns the single-cycle interrupt strobes of a four-channel timer array into four registered output levels. Each channel runs in one of two ways. In toggle mode its level inverts on every strobe of its own counter. In slave mode the strobe of an associated master channel drives the level high and the channel's own strobe drives it low. A master and slave pair of counters therefore yields PWM or one-shot waveforms without any software action per period.

Software sets the block up through a byte-wide write-only bus with three registers: the channel modes, the per-channel output enables, and a direct output level. A newly written mode does not take hold at once. It waits in the background until the channel's output next switches through a strobe while enabled, so a mode change never cuts a waveform in mid-pulse. While a channel is disabled, strobes do not move its level, and software may force that level instead.

Top module: `tmo_ctrl`

## Requirements
- R1: After reset all outputs are 0, all enables are 0 and every channel is in toggle mode.
- R2: An enabled channel in toggle mode inverts its output on its own strobe. The new level appears on `tout` at the clock edge that samples the strobe.
- R3: An enabled channel in slave mode goes to 1 on a strobe of its master channel and goes to 0 on its own strobe. Repeated strobes of the same kind leave the level unchanged.
- R4: A value written to the mode register for a channel is held pending. It becomes the channel's mode at the clock edge of the next output event of that channel while enabled. An output event is a toggle, a set or a reset strobe. That event itself is handled in the old mode.
- R5: Only channels 0 and 2 can be masters. A slave's master is the highest master channel below it whose own mode is toggle. So channel 1 uses channel 0, channel 2 uses channel 0, and channel 3 uses channel 2 while channel 2 is in toggle mode and channel 0 otherwise.
- R6: When a slave channel receives its set strobe and its own reset strobe in the same cycle, its output goes to 0.
- R7: While a channel's enable bit is 0, strobes leave its output unchanged.
- R8: A write to the level register copies data bit k to output k for every channel whose enable bit is 0. Enabled channels ignore the write.
- R9: Mode bit 0 and mode bits 4 to 7 are reserved and have no effect, so channel 0 is always in toggle mode. Enable bits 4 to 7 have no effect.
- R10: Register addresses: 0 is mode (1 = slave), 1 is enable, 2 is level. Bit k always belongs to channel k. A write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data byte |
| irq | input | 4 | Per-channel counter interrupt strobes, one cycle wide |
| tout | output | 4 | Registered channel output levels |

## Verification
Two things can land in the same cycle: a master's set strobe and the slave's own reset strobe. The bench raises both strobes together while channel 1 is in slave mode and expects the output to go low one edge later. A pending mode switch coincides with the output event that activates it in the same way. The bench writes a new mode and then fires the channel's strobe. It judges the result by checking that this strobe still acts in the old mode and that the next master strobe acts in the new one.

// File: rtl/tmo_pkg.sv
// Package: shared register selects and mode encoding for the timer
// output controller. Assumes a 2-bit register address space.
package tmo_pkg;

    localparam int unsigned TMO_ADDR_W = 2;

    typedef enum logic [TMO_ADDR_W-1:0] {
        REG_MODE = 2'd0,
        REG_OEN  = 2'd1,
        REG_LVL  = 2'd2,
        REG_NONE = 2'd3
    } tmo_reg_e;

    typedef enum logic {
        MODE_TOGGLE = 1'b0,
        MODE_SLAVE  = 1'b1
    } tmo_mode_e;

endpackage

// File: rtl/tmo_regs.sv
// Module: tmo_regs
// Holds the pending mode and enable registers written over the byte bus,
// and decodes the level-register write strobe. Assumes NUM_CH <= DATA_W.
// Mode bits of channels that can never be slaves (no master below them)
// and all bits at or above NUM_CH are dropped on write.
module tmo_regs
    import tmo_pkg::*;
#(
    parameter int unsigned NUM_CH      = 4,
    parameter int unsigned DATA_W      = 8,
    parameter logic [NUM_CH-1:0] MASTER_MASK = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TMO_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NUM_CH-1:0] mode_pend,
    output logic [NUM_CH-1:0] oen,
    output logic              lvl_wr,
    output logic [NUM_CH-1:0] lvl_data
);

    // Channels that have at least one master-capable channel below them.
    function automatic logic [NUM_CH-1:0] slave_ok_f();
        logic [NUM_CH-1:0] ok;
        ok = '0;
        for (int k = 1; k < NUM_CH; k++) begin
            for (int j = 0; j < k; j++) begin
                if (MASTER_MASK[j]) ok[k] = 1'b1;
            end
        end
        return ok;
    endfunction

    localparam logic [NUM_CH-1:0] SLAVE_OK = slave_ok_f();

    logic unused_hi;
    assign unused_hi = ^wr_data[DATA_W-1:NUM_CH];

    logic wr_mode;
    logic wr_oen;

    // Decode which register the current bus write targets.
    always_comb begin
        wr_mode = wr_en && (wr_addr == REG_MODE);
        wr_oen  = wr_en && (wr_addr == REG_OEN);
        lvl_wr  = wr_en && (wr_addr == REG_LVL);
    end

    assign lvl_data = wr_data[NUM_CH-1:0];

    // Pending mode register; reserved bits are masked off on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_pend <= '0;
        end else if (wr_mode) begin
            mode_pend <= wr_data[NUM_CH-1:0] & SLAVE_OK;
        end
    end

    // Output enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oen <= '0;
        end else if (wr_oen) begin
            oen <= wr_data[NUM_CH-1:0];
        end
    end

endmodule

// File: rtl/tmo_route.sv
// Module: tmo_route
// Maps each channel to its master and turns the raw strobes into
// per-channel toggle, set and reset requests according to the active
// modes. Purely combinational. Assumes channel 0 is master-capable and
// is never in slave mode, so it is the fallback master.
module tmo_route #(
    parameter int unsigned NUM_CH      = 4,
    parameter logic [NUM_CH-1:0] MASTER_MASK = 4'b0101
) (
    input  logic [NUM_CH-1:0] irq,
    input  logic [NUM_CH-1:0] mode_act,
    output logic [NUM_CH-1:0] tog_req,
    output logic [NUM_CH-1:0] set_req,
    output logic [NUM_CH-1:0] clr_req
);

    // Select the nearest lower master for each channel and build requests.
    always_comb begin
        tog_req = '0;
        set_req = '0;
        clr_req = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            int unsigned mi;
            mi = 0;
            for (int j = 0; j < k; j++) begin
                if (MASTER_MASK[j] && !mode_act[j]) mi = j;
            end
            if (mode_act[k]) begin
                set_req[k] = irq[mi];
                clr_req[k] = irq[k];
            end else begin
                tog_req[k] = irq[k];
            end
        end
    end

endmodule

// File: rtl/tmo_chan.sv
// Module: tmo_chan
// One output channel: the registered output level and the active mode.
// The pending mode is adopted at any output event while enabled; the
// event itself uses the old mode. Reset beats set on a collision.
module tmo_chan
    import tmo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic oen,
    input  logic mode_pend,
    input  logic tog_req,
    input  logic set_req,
    input  logic clr_req,
    input  logic lvl_wr,
    input  logic lvl_bit,
    output logic out_q,
    output logic mode_act
);

    logic evt;
    logic out_d;

    // An output event: any request acting on an enabled channel.
    assign evt = oen && (tog_req || set_req || clr_req);

    // Next output level: enabled strobes first, software level when disabled.
    always_comb begin
        out_d = out_q;
        if (oen) begin
            if (clr_req)      out_d = 1'b0;
            else if (set_req) out_d = 1'b1;
            else if (tog_req) out_d = ~out_q;
        end else if (lvl_wr) begin
            out_d = lvl_bit;
        end
    end

    // Output level register.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= out_d;
    end

    // Active mode register, updated only on an output event.
    always_ff @(posedge clk) begin
        if (!rst_n)   mode_act <= MODE_TOGGLE;
        else if (evt) mode_act <= mode_pend;
    end

endmodule

// File: rtl/tmo_ctrl.sv
// Module: tmo_ctrl (top)
// Timer output controller: register block, master routing and one
// channel slice per timer channel. Strobes are single-cycle pulses.
module tmo_ctrl
    import tmo_pkg::*;
#(
    parameter int unsigned NUM_CH      = 4,
    parameter int unsigned DATA_W      = 8,
    parameter logic [NUM_CH-1:0] MASTER_MASK = 4'b0101
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [TMO_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [NUM_CH-1:0]     irq,
    output logic [NUM_CH-1:0]     tout
);

    logic [NUM_CH-1:0] mode_pend;
    logic [NUM_CH-1:0] mode_act;
    logic [NUM_CH-1:0] oen;
    logic              lvl_wr;
    logic [NUM_CH-1:0] lvl_data;
    logic [NUM_CH-1:0] tog_req;
    logic [NUM_CH-1:0] set_req;
    logic [NUM_CH-1:0] clr_req;

    tmo_regs #(
        .NUM_CH      (NUM_CH),
        .DATA_W      (DATA_W),
        .MASTER_MASK (MASTER_MASK)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .mode_pend (mode_pend),
        .oen       (oen),
        .lvl_wr    (lvl_wr),
        .lvl_data  (lvl_data)
    );

    tmo_route #(
        .NUM_CH      (NUM_CH),
        .MASTER_MASK (MASTER_MASK)
    ) u_route (
        .irq      (irq),
        .mode_act (mode_act),
        .tog_req  (tog_req),
        .set_req  (set_req),
        .clr_req  (clr_req)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tmo_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .oen       (oen[g]),
            .mode_pend (mode_pend[g]),
            .tog_req   (tog_req[g]),
            .set_req   (set_req[g]),
            .clr_req   (clr_req[g]),
            .lvl_wr    (lvl_wr),
            .lvl_bit   (lvl_data[g]),
            .out_q     (tout[g]),
            .mode_act  (mode_act[g])
        );
    end

endmodule

// File: rtl/tmo_ctrl_chk.sv
// Module: tmo_ctrl_chk
// Temporal checks on the timer output controller, bound to the top.
module tmo_ctrl_chk #(
    parameter int unsigned NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] irq,
    input logic [NUM_CH-1:0] tout,
    input logic [NUM_CH-1:0] oen,
    input logic [NUM_CH-1:0] mode_act,
    input logic              lvl_wr
);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
        p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (oen[k] && !mode_act[k] && irq[k]) |=> (tout[k] != $past(tout[k])));

        // Covers R6 as well: an own strobe in slave mode always wins.
        p_slave_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (oen[k] && mode_act[k] && irq[k]) |=> !tout[k]);

        p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !oen[k] |=> $stable(mode_act[k]));

        p_disabled_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!oen[k] && !lvl_wr) |=> $stable(tout[k]));
    end

endmodule

bind tmo_ctrl tmo_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .tout     (tout),
    .oen      (oen),
    .mode_act (mode_act),
    .lvl_wr   (lvl_wr)
);

// File: tb/tmo_ctrl_tb_top.sv
`timescale 1ns/1ps
module tmo_ctrl_tb_top;

    logic       clk;
    logic       rst_n;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic [3:0] irq;
    logic [3:0] tout;

    int n_chk;
    int n_fail;

    logic [3:0] exp_q[$];
    string      req_q[$];

    tmo_ctrl dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .irq     (irq),
        .tout    (tout)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // Driver: one cycle of stimulus, expected output queued for the monitor.
    task automatic cyc(input logic we, input logic [1:0] a, input logic [7:0] d,
                       input logic [3:0] ir, input logic [3:0] e, input string r);
        @(negedge clk);
        wr_en   = we;
        wr_addr = a;
        wr_data = d;
        irq     = ir;
        exp_q.push_back(e);
        req_q.push_back(r);
    endtask

    task automatic strobe(input logic [3:0] ir, input logic [3:0] e, input string r);
        cyc(1'b0, 2'd0, 8'h00, ir, e, r);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [3:0] e,
                      input string r);
        cyc(1'b1, a, d, 4'b0000, e, r);
    endtask

    // Monitor: compare the output just after the edge that consumed the stimulus.
    always @(posedge clk) begin
        #1;
        if (rst_n && exp_q.size() > 0) begin
            logic [3:0] e;
            string      r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            n_chk++;
            if (tout !== e) begin
                n_fail++;
                $display("FAIL %s: tout=%b expected %b", r, tout, e);
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        n_chk = 0; n_fail = 0;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; irq = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (tout !== 4'b0000) begin
            n_fail++;
            $display("FAIL R1: tout=%b expected 0000", tout);
        end
        rst_n = 1'b1;

        wr(2'd1, 8'h0F, 4'b0000, "R10");
        strobe(4'b0001, 4'b0001, "R2");
        strobe(4'b0001, 4'b0000, "R2");
        strobe(4'b1010, 4'b1010, "R1");
        strobe(4'b0010, 4'b1000, "R2");
        // Channel 1 to slave, pending until its next event.
        wr(2'd0, 8'h02, 4'b1000, "R4");
        strobe(4'b0001, 4'b1001, "R4");
        strobe(4'b0010, 4'b1011, "R4");
        strobe(4'b0001, 4'b1010, "R3");
        strobe(4'b0010, 4'b1000, "R3");
        strobe(4'b0010, 4'b1000, "R3");
        strobe(4'b0001, 4'b1011, "R3");
        strobe(4'b0011, 4'b1000, "R6");
        // Disable channel 1.
        wr(2'd1, 8'h0D, 4'b1000, "R7");
        strobe(4'b0011, 4'b1001, "R7");
        wr(2'd2, 8'h0E, 4'b1011, "R8");
        strobe(4'b0010, 4'b1011, "R7");
        wr(2'd3, 8'hFF, 4'b1011, "R10");
        wr(2'd1, 8'h0F, 4'b1011, "R10");
        // Channel 3 as slave of channel 2.
        wr(2'd0, 8'h0A, 4'b1011, "R5");
        strobe(4'b1000, 4'b0011, "R4");
        strobe(4'b0100, 4'b1111, "R5");
        strobe(4'b1000, 4'b0111, "R5");
        strobe(4'b0001, 4'b0110, "R5");
        // Channel 2 also slave: channel 3 falls back to channel 0.
        wr(2'd0, 8'h0E, 4'b0110, "R5");
        strobe(4'b0100, 4'b1010, "R4");
        strobe(4'b1000, 4'b0010, "R5");
        strobe(4'b0001, 4'b1111, "R5");
        strobe(4'b1000, 4'b0111, "R5");
        strobe(4'b0100, 4'b0011, "R5");
        // Reserved mode bits.
        wr(2'd0, 8'hF1, 4'b0011, "R9");
        strobe(4'b0010, 4'b0001, "R9");
        strobe(4'b0010, 4'b0011, "R9");
        strobe(4'b0001, 4'b1110, "R9");
        // Reserved enable bits.
        wr(2'd1, 8'hF0, 4'b1110, "R9");
        strobe(4'b1111, 4'b1110, "R9");
        wr(2'd2, 8'h01, 4'b0001, "R8");

        @(negedge clk);
        wr_en = 1'b0; irq = '0;
        repeat (3) @(posedge clk);
        #2;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule